// File: doc/BRIEF.md
# Ripple-Carry Integer Adder/Subtractor with Signed Overflow Trap

This unit adds or subtracts two 32-bit integers in a single combinational path. Subtraction reuses the adder: the second operand is bit-inverted and a 1 enters as the carry into bit 0. The carry then ripples upward through one full-adder cell per bit. The unit reports the result, the raw carry out of the top bit, and a signed-overflow flag.

The overflow flag comes from the operand and result signs, not from the carry. The second operand can come from the 32-bit input or from a 16-bit immediate. The immediate is sign-extended before use, whatever the overflow policy.

A per-operation trap enable separates signed operations from unsigned-style ones. When the trap enable is set, overflow raises an exception request. When it is clear, the overflow flag is still reported but no request is made. Handling the request is left to the surrounding pipeline.

Top module: `addsub_unit`

## Requirements
- R1: With `sub_sel`=0, `result` equals (A + B) modulo 2^32 and `carry_out` equals bit 32 of the 33-bit unsigned sum.
- R2: With `sub_sel`=1, `result` equals (A − B) modulo 2^32, formed as A + ~B + 1. `carry_out` is the carry out of bit 31 of that sum, which is 1 exactly when A ≥ B as unsigned numbers.
- R3: An addition of operands whose bit 31 values differ never sets `ovf`.
- R4: An addition sets `ovf` exactly when both operands have the same bit 31 and `result` bit 31 differs from it.
- R5: A subtraction sets `ovf` exactly when A and B differ in bit 31 and `result` bit 31 differs from A's bit 31.
- R6: `ovf` does not follow `carry_out`. 0xFFFFFFFF + 1 gives carry 1 with no overflow. 0x7FFFFFFF + 1 gives carry 0 with overflow. 0x80000000 + 0x80000000 gives both.
- R7: With `use_imm`=1, B is `imm16` with its bit 15 copied into bits 31..16, and `opnd_b` has no effect on any output. This holds whatever the value of `trap_en`.
- R8: `exc_req` is 1 exactly when `ovf` and `trap_en` are both 1. With `trap_en`=0, `ovf` is still reported.
- R9: All outputs are a combinational function of the current inputs; with all inputs zero the outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (register path) |
| imm16 | input | 16 | Immediate, sign-extended when selected |
| use_imm | input | 1 | 1 selects the extended immediate as B |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| trap_en | input | 1 | 1 = overflow raises an exception request |
| result | output | 32 | Sum or difference |
| carry_out | output | 1 | Carry out of bit 31 |
| ovf | output | 1 | Signed overflow flag |
| exc_req | output | 1 | Overflow exception request |

## Verification
The bench targets the three boundary sums 0x7FFFFFFF+1, 0x80000000−1 and 0x80000000+0x80000000, together with 0xFFFFFFFF+1.

- A design that derived overflow from the carry would misflag at least one of these.
- A design that forgot the injected carry would be off by one on every difference.
- A design that tested sign equality the wrong way for subtraction would miss the subtraction of a negative value from 0x7FFFFFFF.

Two immediate cases expose a design that zero-extended the immediate: a negative immediate in an add, and 0x8000 in a subtract. The second case also shows that a design gating the flag with the trap enable would lose `ovf`.

// File: rtl/addsub_pkg.sv
// Package: shared widths and flag bundle for the adder/subtractor.
// Assumes the immediate is narrower than the data word.
package addsub_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned IMM_W  = 16;

    // Status bundle carried from the arithmetic core to the top ports.
    typedef struct packed {
        logic carry;
        logic ovf;
        logic exc;
    } flags_t;
endpackage

// File: rtl/addsub_cell.sv
// Module: one full-adder bit of the ripple chain.
// Assumes nothing beyond single-bit inputs; purely combinational.
module addsub_cell (
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_in,
    output logic s_bit,
    output logic c_out
);
    logic half_x;

    // Sum and carry of one bit position.
    always_comb begin
        half_x = a_bit ^ b_bit;
        s_bit  = half_x ^ c_in;
        c_out  = (a_bit & b_bit) | (c_in & half_x);
    end
endmodule

// File: rtl/addsub_opsel.sv
// Module: picks the second operand (register or sign-extended immediate)
// and produces its inverted form for subtraction.
// Assumes IMM_W < DATA_W.
module addsub_opsel #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              pick_imm,
    input  logic              do_sub,
    output logic [DATA_W-1:0] b_sel,
    output logic [DATA_W-1:0] b_feed
);
    logic [DATA_W-1:0] imm_wide;

    // Sign extension: low bits pass, upper bits copy the immediate's MSB.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_ext
        if (gi < IMM_W) begin : g_low
            assign imm_wide[gi] = imm[gi];
        end else begin : g_high
            assign imm_wide[gi] = imm[IMM_W-1];
        end
    end

    // Operand choice and conditional inversion for subtraction.
    always_comb begin
        b_sel  = pick_imm ? imm_wide : reg_b;
        b_feed = do_sub ? ~b_sel : b_sel;
    end

    // Guard the extension: the top bits of a selected immediate agree with its sign (R7).
    always_comb begin
        if (pick_imm) begin
            p_imm_ext_r7: assert (b_sel[DATA_W-1:IMM_W] == {(DATA_W-IMM_W){imm[IMM_W-1]}})
                else $error("immediate not sign-extended");
        end
    end
endmodule

// File: rtl/addsub_ripple.sv
// Module: DATA_W-bit ripple-carry chain of full-adder cells.
// Assumes carry enters at bit 0 and leaves from the top cell.
module addsub_ripple #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              c_first,
    output logic [DATA_W-1:0] s_out,
    output logic              c_last
);
    logic [DATA_W:0] chain;

    assign chain[0] = c_first;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        addsub_cell u_cell (
            .a_bit (a_in[gi]),
            .b_bit (b_in[gi]),
            .c_in  (chain[gi]),
            .s_bit (s_out[gi]),
            .c_out (chain[gi+1])
        );
    end

    assign c_last = chain[DATA_W];
endmodule

// File: rtl/addsub_ovf.sv
// Module: signed overflow from sign relationships of A, B (before
// inversion) and the result. Carry is deliberately not an input.
module addsub_ovf (
    input  logic sgn_a,
    input  logic sgn_b,
    input  logic sgn_r,
    input  logic do_sub,
    output logic ovf_flag
);
    logic signs_match;
    logic sign_flipped;

    // Sign-rule detector for both add and subtract.
    always_comb begin
        signs_match  = (sgn_a == sgn_b);
        sign_flipped = (sgn_r != sgn_a);
        ovf_flag     = (do_sub ? !signs_match : signs_match) && sign_flipped;
    end

    // Addition of opposite-sign operands can never overflow (R3).
    always_comb begin
        if (!do_sub && (sgn_a != sgn_b)) begin
            p_no_overflow_r3: assert (!ovf_flag) else $error("overflow on mixed-sign add");
        end
    end
endmodule

// File: rtl/addsub_unit.sv
// Module: top of the two's complement adder/subtractor.
// Combinational; no state, so no clock or reset is needed.
// Assumes the caller acts on exc_req in the same cycle.
module addsub_unit #(
    parameter int unsigned DATA_W = addsub_pkg::WORD_W,
    parameter int unsigned IMM_W  = addsub_pkg::IMM_W
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm16,
    input  logic              use_imm,
    input  logic              sub_sel,
    input  logic              trap_en,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              ovf,
    output logic              exc_req
);
    import addsub_pkg::*;

    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_chosen;
    logic [DATA_W-1:0] b_to_chain;
    logic [DATA_W-1:0] sum_w;
    logic              c_top;
    logic              ovf_w;
    flags_t            flg;

    addsub_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .reg_b    (opnd_b),
        .imm      (imm16),
        .pick_imm (use_imm),
        .do_sub   (sub_sel),
        .b_sel    (b_chosen),
        .b_feed   (b_to_chain)
    );

    addsub_ripple #(.DATA_W(DATA_W)) u_chain (
        .a_in    (opnd_a),
        .b_in    (b_to_chain),
        .c_first (sub_sel),
        .s_out   (sum_w),
        .c_last  (c_top)
    );

    addsub_ovf u_ovf (
        .sgn_a    (opnd_a[MSB]),
        .sgn_b    (b_chosen[MSB]),
        .sgn_r    (sum_w[MSB]),
        .do_sub   (sub_sel),
        .ovf_flag (ovf_w)
    );

    // Bundle the status and apply the per-operation trap policy.
    always_comb begin
        flg.carry = c_top;
        flg.ovf   = ovf_w;
        flg.exc   = ovf_w & trap_en;
    end

    // Drive the top ports.
    always_comb begin
        result    = sum_w;
        carry_out = flg.carry;
        ovf       = flg.ovf;
        exc_req   = flg.exc;
    end

    // Cross-check the ripple chain against behavioural arithmetic (R1, R2).
    always_comb begin
        if (!sub_sel) begin
            p_add_value_r1: assert ({carry_out, result} == ({1'b0, opnd_a} + {1'b0, b_chosen}))
                else $error("ripple sum mismatch");
        end else begin
            p_sub_value_r2: assert (result == DATA_W'(opnd_a - b_chosen) && carry_out == (opnd_a >= b_chosen))
                else $error("ripple difference mismatch");
        end
    end

    // No exception request may leave the unit when trapping is off (R8).
    always_comb begin
        if (!trap_en) begin
            p_no_trap_r8: assert (!exc_req) else $error("exception with trap disabled");
        end
    end
endmodule

// File: tb/addsub_unit_tb_top.sv
`timescale 1ns/1ps
module addsub_unit_tb_top;
    localparam int NV = 12;
    localparam int VW = 32 + 32 + 16 + 3;

    // Each entry: {A, B, imm16, use_imm, sub_sel, trap_en}
    localparam logic [VW-1:0] VEC [NV] = '{
        {32'h0000_0005, 32'h0000_0003, 16'h0000, 1'b0, 1'b0, 1'b1},
        {32'h0000_0005, 32'h0000_0003, 16'h0000, 1'b0, 1'b1, 1'b1},
        {32'h0000_0003, 32'h0000_0005, 16'h0000, 1'b0, 1'b1, 1'b1},
        {32'h7FFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0, 1'b0, 1'b1},
        {32'h8000_0000, 32'h0000_0001, 16'h0000, 1'b0, 1'b1, 1'b1},
        {32'h8000_0000, 32'h8000_0000, 16'h0000, 1'b0, 1'b0, 1'b1},
        {32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 1'b0, 1'b0, 1'b1},
        {32'h7FFF_FFFF, 32'h8000_0000, 16'h0000, 1'b0, 1'b0, 1'b1},
        {32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 1'b0, 1'b1, 1'b1},
        {32'h1234_5678, 32'hDEAD_BEEF, 16'hFFFE, 1'b1, 1'b0, 1'b1},
        {32'h7FFF_FFFF, 32'h0000_0000, 16'h8000, 1'b1, 1'b1, 1'b0},
        {32'hA5A5_A5A5, 32'h5A5A_5A5A, 16'h0000, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] imm16 = '0;
    logic use_imm = 1'b0, sub_sel = 1'b0, trap_en = 1'b0;
    logic [31:0] result;
    logic carry_out, ovf, exc_req;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    addsub_unit dut_i (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16), .use_imm(use_imm),
        .sub_sel(sub_sel), .trap_en(trap_en), .result(result),
        .carry_out(carry_out), .ovf(ovf), .exc_req(exc_req)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                         input logic ui, input logic sb, input logic te);
        @(negedge clk);
        opnd_a = a; opnd_b = b; imm16 = im; use_imm = ui; sub_sel = sb; trap_en = te;
        #2;
    endtask

    // Reference computed from the requirements using wide signed arithmetic.
    task automatic verify(input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                          input logic ui, input logic sb, input logic te);
        logic [31:0] bx;
        longint la, lb, tru;
        logic e_ovf, e_car;
        bx  = ui ? {{16{im[15]}}, im} : b;
        la  = longint'($signed(a));
        lb  = longint'($signed(bx));
        tru = sb ? la - lb : la + lb;
        e_ovf = (tru > 64'sd2147483647) || (tru < -64'sd2147483648);
        e_car = sb ? (a >= bx) : (({1'b0, a} + {1'b0, bx}) >> 32) != 33'd0;
        check(sb ? "R2 result" : "R1 result", 64'(result), 64'(tru[31:0]));
        check(sb ? "R2 carry" : "R1 carry", 64'(carry_out), 64'(e_car));
        check(sb ? "R5 ovf" : "R4 ovf", 64'(ovf), 64'(e_ovf));
        check("R8 exc", 64'(exc_req), 64'(e_ovf & te));
    endtask

    initial begin
        logic [31:0] keep_r;
        logic keep_o;
        // R9: quiescent state with zero inputs during reset.
        repeat (3) @(posedge clk);
        #2;
        check("R9 zero state", {result, carry_out, ovf, exc_req}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            drive(v[82:51], v[50:19], v[18:3], v[2], v[1], v[0]);
            verify(v[82:51], v[50:19], v[18:3], v[2], v[1], v[0]);
        end

        // R6: boundary sums, carry and overflow independent.
        drive(32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, 1'b1);
        check("R6 7FFFFFFF+1", {result, carry_out, ovf}, {32'h8000_0000, 1'b0, 1'b1});
        drive(32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, 1'b1);
        check("R6 FFFFFFFF+1", {result, carry_out, ovf}, {32'h0, 1'b1, 1'b0});
        drive(32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0, 1'b0, 1'b1);
        check("R6 80000000+80000000", {result, carry_out, ovf}, {32'h0, 1'b1, 1'b1});
        drive(32'h8000_0000, 32'h1, 16'h0, 1'b0, 1'b1, 1'b1);
        check("R5 80000000-1", {result, ovf, exc_req}, {32'h7FFF_FFFF, 1'b1, 1'b1});

        // R3: opposite-sign add at the extremes.
        drive(32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0, 1'b0, 1'b1);
        check("R3 mixed add", {result, ovf}, {32'hFFFF_FFFF, 1'b0});

        // R7: opnd_b has no effect while the immediate is selected.
        drive(32'h0000_0010, 32'h0000_0000, 16'h8001, 1'b1, 1'b0, 1'b0);
        keep_r = result; keep_o = ovf;
        check("R7 imm neg", 64'(result), 64'(32'hFFFF_8011));
        drive(32'h0000_0010, 32'hFFFF_FFFF, 16'h8001, 1'b1, 1'b0, 1'b0);
        check("R7 opnd_b ignored", {result, ovf}, {keep_r, keep_o});

        // R8: same overflowing op with and without trap.
        drive(32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, 1'b0);
        check("R8 trap off", {ovf, exc_req}, 2'b10);
        drive(32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 1'b0, 1'b1);
        check("R8 trap on", {ovf, exc_req}, 2'b11);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule